// File: doc/BRIEF.md
# Memory Access Scope Checker

This block sits beside a bus monitor and judges each data access a program makes against a few coarse rules kept for each function. A decoder upstream reports every load or store: its address, whether it writes, the index of the function that is running, and whether the access is the save or restore of the frame pointer. The block answers one cycle later with two verdicts. A code verdict means something wrote into the protected code image. A data verdict means the running function touched memory its rules forbid: a global area it was never meant to use, or the stack frame of a caller.

The rules for each function are loaded once at configuration time: a flag that allows global or heap access, a flag that allows stack accesses through pointers handed down by a caller, and a byte count for arguments that the caller leaves on the stack. The code range and the stack range are also written at configuration time. The block needs no view of processor registers. It rebuilds the frame pointer from bus traffic alone. A frame-pointer save gives the new value as the address written. A frame-pointer restore gives it as the data read. The stack grows downward.

Top module: `scope_access_checker`

## Requirements
- R1: A write access whose address lies in the code range [code_lo, code_hi) raises code_viol_o in the cycle after the access is presented.
- R2: A read access never raises code_viol_o. A read inside the code range never raises data_viol_o either, under any policy.
- R3: When the running function's globals flag is 0, any access that lies outside both the stack range [stack_lo, stack_hi) and the code range raises data_viol_o.
- R4: When the running function's by-reference flag is 0, a stack-range access at an address strictly greater than frame pointer plus stack-argument offset raises data_viol_o. An access at or below that boundary does not.
- R5: The stack-argument offset is a per-function byte count (pol_argofs_i). It moves the R4 boundary up by exactly that many bytes.
- R6: An access with acc_fp_i=1 and acc_write_i=1 (frame-pointer save) sets the frame-pointer copy to the access address. The verdict for that access itself uses the old copy.
- R7: An access with acc_fp_i=1 and acc_write_i=0 (frame-pointer restore) sets the frame-pointer copy to acc_rdata_i. The verdict for that access itself uses the old copy.
- R8: When a function has both the globals flag and the by-reference flag set to 1, no access of that function raises data_viol_o.
- R9: After reset both verdicts are 0, all four range bounds are 0, every policy entry is all-zero, and the frame-pointer copy is all ones, so R4 flags nothing before the first save.
- R10: Each verdict is a one-cycle pulse that follows a valid access. With acc_valid_i=0 both verdicts are 0 in the next cycle. A code verdict suppresses the data verdict for the same access.
- R11: Range bounds are written with cfg_we_i and the cfg_sel_i encoding 0=code lower, 1=code upper, 2=stack lower, 3=stack upper. Policy entries are written with pol_we_i at index pol_idx_i. Writes to an index of FN or above are dropped, and reads from such an index give the all-zero policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Range bound write strobe |
| cfg_sel_i | input | 2 | Bound select: 0 code lo, 1 code hi, 2 stack lo, 3 stack hi |
| cfg_data_i | input | AW | Bound value |
| pol_we_i | input | 1 | Policy entry write strobe |
| pol_idx_i | input | $clog2(FN) | Function index of the policy write |
| pol_glob_i | input | 1 | Policy: function may access globals/heap |
| pol_byref_i | input | 1 | Policy: function accepts by-reference arguments |
| pol_argofs_i | input | OW | Policy: stack-argument size in bytes |
| acc_valid_i | input | 1 | A data access is presented this cycle |
| acc_write_i | input | 1 | 1 = store, 0 = load |
| acc_fp_i | input | 1 | Access is a frame-pointer save/restore |
| acc_addr_i | input | AW | Data address of the access |
| acc_rdata_i | input | AW | Data read (used on frame-pointer restore) |
| func_idx_i | input | $clog2(FN) | Index of the active function |
| code_viol_o | output | 1 | Code-range write detected (pulse) |
| data_viol_o | output | 1 | Scope rule broken (pulse) |

## Verification
Every function policy (each mix of the two flags with a distinct argument offset) is swept with loads and stores over addresses placed on each range edge and on both sides of the caller-frame boundary. This separates off-by-one errors in the inclusive and exclusive bounds from errors in the offset arithmetic and in flag decoding. The sweep runs three times: with the reset frame pointer, after a save, and after a restore. Only the save and restore move the boundary, so a tracker that takes the wrong bus field or updates too early shows up in the second and third sweeps. Separate vectors reprogram the ranges and a policy entry, and test the idle cycles that follow a violation.

// File: rtl/scope_pkg.sv
package scope_pkg;
  typedef enum logic [1:0] {
    SEL_CODE_LO  = 2'd0,
    SEL_CODE_HI  = 2'd1,
    SEL_STACK_LO = 2'd2,
    SEL_STACK_HI = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic glob;
    logic byref;
  } pol_flags_t;
endpackage

// File: rtl/scope_range_cmp.sv
module scope_range_cmp #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  assign hit_o = (addr_i >= lo_i) && (addr_i < hi_i);
endmodule

// File: rtl/scope_policy_table.sv
module scope_policy_table
  import scope_pkg::*;
#(
  parameter int FN  = 8,
  parameter int OW  = 8,
  parameter int FIW = (FN > 1) ? $clog2(FN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [FIW-1:0]   widx_i,
  input  pol_flags_t       wflags_i,
  input  logic [OW-1:0]    wofs_i,
  input  logic [FIW-1:0]   ridx_i,
  output pol_flags_t       rflags_o,
  output logic [OW-1:0]    rofs_o
);
  pol_flags_t          flags_q [FN];
  logic [OW-1:0]       ofs_q   [FN];

  for (genvar g = 0; g < FN; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flags_q[g] <= '0;
        ofs_q[g]   <= '0;
      end else if (we_i && (32'(widx_i) == g)) begin
        flags_q[g] <= wflags_i;
        ofs_q[g]   <= wofs_i;
      end
    end
  end

  always_comb begin
    rflags_o = '0;
    rofs_o   = '0;
    for (int i = 0; i < FN; i++) begin
      if (32'(ridx_i) == i) begin
        rflags_o = flags_q[i];
        rofs_o   = ofs_q[i];
      end
    end
  end
endmodule

// File: rtl/scope_fp_tracker.sv
module scope_fp_tracker #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          fp_acc_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] rdata_i,
  output logic [AW-1:0] fp_o
);
  logic [AW-1:0] fp_q;

  // save: slot address becomes the frame base; restore: popped word does
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                fp_q <= '1;
    else if (valid_i && fp_acc_i) fp_q <= write_i ? addr_i : rdata_i;
  end

  assign fp_o = fp_q;
endmodule

// File: rtl/scope_access_checker.sv
module scope_access_checker
  import scope_pkg::*;
#(
  parameter int AW  = 16,
  parameter int FN  = 8,
  parameter int OW  = 8,
  localparam int FIW = (FN > 1) ? $clog2(FN) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_we_i,
  input  logic [1:0]     cfg_sel_i,
  input  logic [AW-1:0]  cfg_data_i,
  input  logic           pol_we_i,
  input  logic [FIW-1:0] pol_idx_i,
  input  logic           pol_glob_i,
  input  logic           pol_byref_i,
  input  logic [OW-1:0]  pol_argofs_i,
  input  logic           acc_valid_i,
  input  logic           acc_write_i,
  input  logic           acc_fp_i,
  input  logic [AW-1:0]  acc_addr_i,
  input  logic [AW-1:0]  acc_rdata_i,
  input  logic [FIW-1:0] func_idx_i,
  output logic           code_viol_o,
  output logic           data_viol_o
);
  localparam int BW = AW + 1;

  logic [AW-1:0] code_lo_q, code_hi_q, stack_lo_q, stack_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_lo_q  <= '0;
      code_hi_q  <= '0;
      stack_lo_q <= '0;
      stack_hi_q <= '0;
    end else if (cfg_we_i) begin
      case (cfg_sel_e'(cfg_sel_i))
        SEL_CODE_LO:  code_lo_q  <= cfg_data_i;
        SEL_CODE_HI:  code_hi_q  <= cfg_data_i;
        SEL_STACK_LO: stack_lo_q <= cfg_data_i;
        default:      stack_hi_q <= cfg_data_i;
      endcase
    end
  end

  pol_flags_t    cur_flags;
  logic [OW-1:0] cur_ofs;
  pol_flags_t    wr_flags;
  assign wr_flags = '{glob: pol_glob_i, byref: pol_byref_i};

  scope_policy_table #(.FN(FN), .OW(OW), .FIW(FIW)) u_pol (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (pol_we_i),
    .widx_i   (pol_idx_i),
    .wflags_i (wr_flags),
    .wofs_i   (pol_argofs_i),
    .ridx_i   (func_idx_i),
    .rflags_o (cur_flags),
    .rofs_o   (cur_ofs)
  );

  logic [AW-1:0] fp_q;

  scope_fp_tracker #(.AW(AW)) u_fp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (acc_valid_i),
    .fp_acc_i (acc_fp_i),
    .write_i  (acc_write_i),
    .addr_i   (acc_addr_i),
    .rdata_i  (acc_rdata_i),
    .fp_o     (fp_q)
  );

  logic in_code, in_stack;

  scope_range_cmp #(.AW(AW)) u_code_rng (
    .lo_i (code_lo_q), .hi_i (code_hi_q), .addr_i (acc_addr_i), .hit_o (in_code)
  );
  scope_range_cmp #(.AW(AW)) u_stack_rng (
    .lo_i (stack_lo_q), .hi_i (stack_hi_q), .addr_i (acc_addr_i), .hit_o (in_stack)
  );

  // caller-frame boundary kept one bit wider so fp + offset cannot wrap
  logic [BW-1:0] frame_top;
  logic          above_frame;
  assign frame_top   = {1'b0, fp_q} + BW'(cur_ofs);
  assign above_frame = {1'b0, acc_addr_i} > frame_top;

  logic cur_glob, cur_byref;
  assign cur_glob  = cur_flags.glob;
  assign cur_byref = cur_flags.byref;

  logic code_hit, glob_bad, frame_bad, code_d, data_d;
  assign code_hit  = acc_write_i && in_code;
  assign glob_bad  = !cur_glob && !in_stack && !in_code;
  assign frame_bad = !cur_byref && in_stack && above_frame;
  assign code_d    = acc_valid_i && code_hit;
  assign data_d    = acc_valid_i && !code_hit && (glob_bad || frame_bad);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_viol_o <= 1'b0;
      data_viol_o <= 1'b0;
    end else begin
      code_viol_o <= code_d;
      data_viol_o <= data_d;
    end
  end
endmodule

// File: rtl/scope_access_checker_sva.sv
module scope_access_checker_sva #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          acc_valid_i,
  input logic          acc_write_i,
  input logic          acc_fp_i,
  input logic [AW-1:0] acc_addr_i,
  input logic [AW-1:0] acc_rdata_i,
  input logic [AW-1:0] code_lo_q,
  input logic [AW-1:0] code_hi_q,
  input logic [AW-1:0] fp_q,
  input logic          cur_glob,
  input logic          cur_byref,
  input logic          code_viol_o,
  input logic          data_viol_o
);
  assert_code_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_write_i && (acc_addr_i >= code_lo_q) && (acc_addr_i < code_hi_q)
    |=> code_viol_o);

  assert_read_no_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !acc_write_i |=> !code_viol_o);

  assert_fp_save_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_fp_i && acc_write_i |=> fp_q == $past(acc_addr_i));

  assert_fp_restore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_fp_i && !acc_write_i |=> fp_q == $past(acc_rdata_i));

  assert_permissive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && cur_glob && cur_byref |=> !data_viol_o);

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !code_viol_o && !data_viol_o);

  assert_one_verdict_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(code_viol_o && data_viol_o));
endmodule

bind scope_access_checker scope_access_checker_sva #(.AW(AW)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_write_i (acc_write_i),
  .acc_fp_i    (acc_fp_i),
  .acc_addr_i  (acc_addr_i),
  .acc_rdata_i (acc_rdata_i),
  .code_lo_q   (code_lo_q),
  .code_hi_q   (code_hi_q),
  .fp_q        (fp_q),
  .cur_glob    (cur_glob),
  .cur_byref   (cur_byref),
  .code_viol_o (code_viol_o),
  .data_viol_o (data_viol_o)
);

// File: tb/scope_access_checker_tb_top.sv
`timescale 1ns/1ps
module scope_access_checker_tb_top;
  localparam int AW = 16;
  localparam int FN = 8;
  localparam int OW = 8;
  localparam int FIW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           cfg_we = 0;
  logic [1:0]     cfg_sel = 0;
  logic [AW-1:0]  cfg_data = 0;
  logic           pol_we = 0;
  logic [FIW-1:0] pol_idx = 0;
  logic           pol_glob = 0, pol_byref = 0;
  logic [OW-1:0]  pol_ofs = 0;
  logic           acc_valid = 0, acc_write = 0, acc_fp = 0;
  logic [AW-1:0]  acc_addr = 0, acc_rdata = 0;
  logic [FIW-1:0] func_idx = 0;
  logic           code_viol, data_viol;

  scope_access_checker #(.AW(AW), .FN(FN), .OW(OW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .pol_we_i(pol_we), .pol_idx_i(pol_idx), .pol_glob_i(pol_glob),
    .pol_byref_i(pol_byref), .pol_argofs_i(pol_ofs),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_fp_i(acc_fp),
    .acc_addr_i(acc_addr), .acc_rdata_i(acc_rdata), .func_idx_i(func_idx),
    .code_viol_o(code_viol), .data_viol_o(data_viol)
  );

  int n_chk = 0, n_bad = 0;
  int m_clo = 0, m_chi = 0, m_slo = 0, m_shi = 0;
  int m_fp = 32'hFFFF;
  bit m_glob [FN];
  bit m_byref [FN];
  int m_ofs [FN];

  task automatic check(input string req, input bit act_c, input bit act_d,
                       input bit exp_c, input bit exp_d);
    n_chk++;
    if (act_c !== exp_c || act_d !== exp_d) begin
      n_bad++;
      $display("FAIL %s: code/data actual %b%b expected %b%b", req, act_c, act_d, exp_c, exp_d);
    end
  endtask

  task automatic set_cfg(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_data = AW'(val);
    @(negedge clk);
    cfg_we = 0;
    case (sel)
      0: m_clo = val;
      1: m_chi = val;
      2: m_slo = val;
      default: m_shi = val;
    endcase
  endtask

  task automatic set_pol(input int f, input bit g, input bit b, input int ofs);
    @(negedge clk);
    pol_we = 1; pol_idx = FIW'(f); pol_glob = g; pol_byref = b; pol_ofs = OW'(ofs);
    @(negedge clk);
    pol_we = 0;
    m_glob[f] = g; m_byref[f] = b; m_ofs[f] = ofs;
  endtask

  // one access; verdict sampled at the negedge after the capturing posedge
  task automatic do_acc(input string phase, input bit wr, input bit fp, input int a,
                        input int rd, input int f);
    bit in_c, in_s, ec, ed;
    string tag;
    in_c = (a >= m_clo) && (a < m_chi);
    in_s = (a >= m_slo) && (a < m_shi);
    ec = wr && in_c;
    ed = !ec && ((!m_glob[f] && !in_s && !in_c) ||
                 (!m_byref[f] && in_s && (a > m_fp + m_ofs[f])));
    if (ec) tag = "R1";
    else if (in_c) tag = "R2";
    else if (m_glob[f] && m_byref[f]) tag = "R8";
    else if (!m_glob[f] && !in_s) tag = "R3";
    else if (!m_byref[f] && in_s) tag = (m_ofs[f] != 0) ? "R5" : "R4";
    else tag = "R10";
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_fp = fp; acc_addr = AW'(a);
    acc_rdata = AW'(rd); func_idx = FIW'(f);
    @(negedge clk);
    acc_valid = 0; acc_fp = 0;
    check({phase, "/", tag}, code_viol, data_viol, ec, ed);
    if (fp) m_fp = wr ? a : rd;
  endtask

  function automatic int probe_addr(input int k, input int base);
    int d [7] = '{-4, 0, 1, 8, 9, 28, 29};
    case (k)
      0: return m_clo - 1;
      1: return m_clo;
      2: return m_chi - 1;
      3: return m_chi;
      4: return 32'h4000;
      5: return m_slo - 1;
      6: return m_slo;
      7: return m_shi - 1;
      8: return m_shi;
      default: return base + d[k-9];
    endcase
  endfunction

  task automatic sweep(input string phase, input int base);
    for (int f = 0; f < FN; f++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 16; k++)
          do_acc(phase, w[0], 1'b0, probe_addr(k, base), 0, f);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int f = 0; f < FN; f++) begin m_glob[f] = 0; m_byref[f] = 0; m_ofs[f] = 0; end
    repeat (3) @(negedge clk);
    check("R9 reset", code_viol, data_viol, 0, 0);
    rst_n = 1;
    @(negedge clk);
    check("R9 post-reset", code_viol, data_viol, 0, 0);
    // R9: all-zero policy and empty ranges -> every non-code access is a global violation
    do_acc("R9", 1'b0, 1'b0, 32'h1234, 0, 0);

    set_cfg(0, 32'h0100); set_cfg(1, 32'h0200);
    set_cfg(2, 32'h8000); set_cfg(3, 32'h9000);
    for (int f = 0; f < FN; f++) set_pol(f, f[0], f[1], f * 4);

    sweep("R9", 32'h8800);
    do_acc("R6", 1'b1, 1'b1, 32'h8800, 0, 0);
    sweep("R6", m_fp);
    do_acc("R7", 1'b0, 1'b1, 32'h8800, 32'h8A00, 0);
    sweep("R7", m_fp);

    // R10: a violation is followed by silence on an idle cycle
    do_acc("R10", 1'b1, 1'b0, 32'h0150, 0, 3);
    @(negedge clk);
    check("R10 idle", code_viol, data_viol, 0, 0);

    // R11: move the code range and rewrite one policy entry
    set_cfg(0, 32'h0300); set_cfg(1, 32'h0400);
    do_acc("R11", 1'b1, 1'b0, 32'h0350, 0, 3);
    do_acc("R11", 1'b1, 1'b0, 32'h0150, 0, 0);
    set_pol(3, 1'b0, 1'b0, 0);
    do_acc("R11", 1'b0, 1'b0, 32'h4000, 0, 3);
    do_acc("R11", 1'b0, 1'b0, 32'h8A01, 0, 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule